// File: doc/BRIEF.md
# Console I/O Register Block

This block sits on the processor's memory bus beside ordinary memory. It claims five fixed word addresses: keyboard status, keyboard data, display status, display data and machine control. All other bus traffic passes through to memory. Reads of the five addresses return the register value in the same cycle that a memory read would return, so the core cannot tell a device register from a memory word.

Characters come in on a byte-wide valid input and go out on a byte-wide valid output. The core raises a one-cycle step strobe at each instruction boundary, and the block does its per-instruction housekeeping on that strobe:
- A pending display character is drained.
- The display status goes through its busy and ready states.
- An idle counter ages the keyboard ready bit, so the bit drops by itself when no new character has come for a few steps.

The machine control register drives a run signal, and the core halts once software writes zero to that register.

Top module: `console_regs`

## Requirements
- R1: After reset, keyboard status, keyboard data and display data read 0x0000, display status reads 0xFFFF, machine control reads 0x0001, `run_o` is 1 and `out_valid_o` is 0.
- R2: A bus read returns the register combinationally when the address is one of the following, and otherwise returns `mem_rdata_i` in the same cycle:
  - 0xFE00 for keyboard status
  - 0xFE02 for keyboard data
  - 0xFE04 for display status
  - 0xFE06 for display data
  - 0xFFFE for machine control
- R3: A bus write to one of the five addresses loads the full 16-bit register on the next edge and keeps `mem_we_o` low. A write to any other address, neighbours such as 0xFE01 included, raises `mem_we_o` and changes no register.
- R4: `run_o` is 1 exactly when machine control is nonzero. Writing 0 to machine control makes `run_o` low from the next cycle on, and writing a nonzero value raises it again.
- R5: When `in_valid_i` is high, the next edge loads keyboard data with the character zero-extended to 16 bits, sets keyboard status bit 15, keeps the other status bits, and clears the idle counter.
- R6: Each step without an arriving character advances the idle counter. Keyboard status bit 15 stays set through the first two such steps after an arrival and is cleared on the third, and the other status bits are untouched.
- R7: On a step where display status bit 15 is 1 and display data is nonzero, `out_char_o` presents the low byte of display data and `out_valid_o` is high for exactly one cycle after that edge. Display data becomes 0x0000 and display status becomes 0x0001 (busy).
- R8: On a step that does not emit, display status returns to 0xFFFF and display data is kept. A character written while the display is busy is therefore emitted one step later. With display data at zero, no character is emitted.
- R9: A bus write takes priority over a same-cycle step update of the register it targets, and the emit decision uses the values held before that edge. A character arriving on the same cycle as a step sets the ready bit and restarts the idle count.
- R10: Between steps, with no bus write and no arrival, the status and data registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | One-cycle strobe per executed instruction |
| bus_addr_i | input | 16 | Bus word address |
| bus_we_i | input | 1 | Bus write enable |
| bus_wdata_i | input | 16 | Bus write data |
| bus_rdata_o | output | 16 | Bus read data (register or memory) |
| mem_rdata_i | input | 16 | Read data from ordinary memory |
| mem_we_o | output | 1 | Write enable forwarded to memory |
| in_valid_i | input | 1 | Incoming character valid |
| in_char_i | input | 8 | Incoming character code |
| out_valid_o | output | 1 | Outgoing character valid pulse |
| out_char_o | output | 8 | Outgoing character code |
| run_o | output | 1 | Run enable from machine control |

## Verification
The bench reads addresses both inside the decoded set and at its neighbours. This separates a full compare from one that drops low address bits, and a register hit from a memory pass-through.

The keyboard is driven in several patterns:
- A single arrival followed by idle steps, which finds the exact step on which the ready bit expires.
- A second arrival before expiry, which shows the counter restarts.
- An arrival on the same cycle as a step.

The display is driven in these patterns:
- Back-to-back characters, which expose the one-step busy phase.
- A zero data word.
- A data write on the emitting step, which shows write priority and that the emit uses the values held before the edge.

// File: rtl/console_pkg.sv
package console_pkg;
  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_KSTAT = 3'd1,
    SEL_KDATA = 3'd2,
    SEL_DSTAT = 3'd3,
    SEL_DDATA = 3'd4,
    SEL_MCTL = 3'd5
  } reg_sel_e;
  localparam int unsigned NUM_REGS = 5;
endpackage

// File: rtl/console_decode.sv
module console_decode
  import console_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter logic [ADDR_W-1:0] KSTAT_A = 16'hFE00,
  parameter logic [ADDR_W-1:0] KDATA_A = 16'hFE02,
  parameter logic [ADDR_W-1:0] DSTAT_A = 16'hFE04,
  parameter logic [ADDR_W-1:0] DDATA_A = 16'hFE06,
  parameter logic [ADDR_W-1:0] MCTL_A = 16'hFFFE
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] kstat_i,
  input  logic [DATA_W-1:0] kdata_i,
  input  logic [DATA_W-1:0] dstat_i,
  input  logic [DATA_W-1:0] ddata_i,
  input  logic [DATA_W-1:0] mctl_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output reg_sel_e          sel_o,
  output logic              hit_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] ADDRS [NUM_REGS] = '{KSTAT_A, KDATA_A, DSTAT_A, DDATA_A, MCTL_A};

  logic [DATA_W-1:0] vals [NUM_REGS];
  assign vals[0] = kstat_i;
  assign vals[1] = kdata_i;
  assign vals[2] = dstat_i;
  assign vals[3] = ddata_i;
  assign vals[4] = mctl_i;

  always_comb begin
    sel_o   = SEL_NONE;
    rdata_o = mem_rdata_i;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr_i == ADDRS[i]) begin
        sel_o   = reg_sel_e'(i + 1);
        rdata_o = vals[i];
      end
    end
  end

  assign hit_o = (sel_o != SEL_NONE);
endmodule

// File: rtl/console_kbd.sv
module console_kbd #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned IDLE_LIMIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              in_valid_i,
  input  logic [CHAR_W-1:0] in_char_i,
  input  logic              wr_stat_i,
  input  logic              wr_data_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] stat_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned CNT_W = $clog2(IDLE_LIMIT + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IDLE_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(IDLE_LIMIT);

  logic [CNT_W-1:0] idle_q, idle_nx;
  logic             expire;

  // saturate so a long idle stretch cannot wrap back under the limit
  assign idle_nx = (idle_q == CNT_MAX) ? idle_q : idle_q + 1'b1;
  assign expire  = step_i && !in_valid_i && (idle_nx > CNT_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
      stat_o <= '0;
      data_o <= '0;
    end else begin
      if (in_valid_i) idle_q <= '0;
      else if (step_i) idle_q <= idle_nx;

      if (wr_stat_i) stat_o <= wdata_i;
      else if (in_valid_i) stat_o[DATA_W-1] <= 1'b1;
      else if (expire) stat_o[DATA_W-1] <= 1'b0;

      if (wr_data_i) data_o <= wdata_i;
      else if (in_valid_i) data_o <= {{(DATA_W-CHAR_W){1'b0}}, in_char_i};
    end
  end

  // R5
  arrive_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !wr_stat_i) |=> stat_o[DATA_W-1]);

  // R10
  kbd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && !step_i && !wr_stat_i) |=> $stable(stat_o));
endmodule

// File: rtl/console_disp.sv
module console_disp #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              wr_stat_i,
  input  logic              wr_data_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] stat_o,
  output logic [DATA_W-1:0] data_o,
  output logic              out_valid_o,
  output logic [CHAR_W-1:0] out_char_o
);
  localparam logic [DATA_W-1:0] BUSY = DATA_W'(1);

  logic emit;
  assign emit = step_i && stat_o[DATA_W-1] && (data_o != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o      <= '1;
      data_o      <= '0;
      out_valid_o <= 1'b0;
      out_char_o  <= '0;
    end else begin
      out_valid_o <= emit;
      if (emit) out_char_o <= data_o[CHAR_W-1:0];

      if (wr_stat_i) stat_o <= wdata_i;
      else if (step_i) stat_o <= emit ? BUSY : '1;

      if (wr_data_i) data_o <= wdata_i;
      else if (emit) data_o <= '0;
    end
  end

  // R7
  emit_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  // R10
  disp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !wr_stat_i) |=> $stable(stat_o));
endmodule

// File: rtl/console_regs.sv
module console_regs
  import console_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned IDLE_LIMIT = 2,
  parameter logic [ADDR_W-1:0] KSTAT_A = 16'hFE00,
  parameter logic [ADDR_W-1:0] KDATA_A = 16'hFE02,
  parameter logic [ADDR_W-1:0] DSTAT_A = 16'hFE04,
  parameter logic [ADDR_W-1:0] DDATA_A = 16'hFE06,
  parameter logic [ADDR_W-1:0] MCTL_A = 16'hFFFE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_we_o,
  input  logic              in_valid_i,
  input  logic [CHAR_W-1:0] in_char_i,
  output logic              out_valid_o,
  output logic [CHAR_W-1:0] out_char_o,
  output logic              run_o
);
  reg_sel_e          sel;
  logic              hit;
  logic [DATA_W-1:0] kstat, kdata, dstat, ddata, mctl_q;
  logic              wr_mctl;

  console_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KSTAT_A(KSTAT_A), .KDATA_A(KDATA_A),
    .DSTAT_A(DSTAT_A), .DDATA_A(DDATA_A), .MCTL_A(MCTL_A)
  ) i_decode (
    .addr_i(bus_addr_i), .kstat_i(kstat), .kdata_i(kdata), .dstat_i(dstat),
    .ddata_i(ddata), .mctl_i(mctl_q), .mem_rdata_i(mem_rdata_i),
    .sel_o(sel), .hit_o(hit), .rdata_o(bus_rdata_o)
  );

  console_kbd #(.DATA_W(DATA_W), .CHAR_W(CHAR_W), .IDLE_LIMIT(IDLE_LIMIT)) i_kbd (
    .clk_i, .rst_ni, .step_i, .in_valid_i, .in_char_i,
    .wr_stat_i(bus_we_i && sel == SEL_KSTAT),
    .wr_data_i(bus_we_i && sel == SEL_KDATA),
    .wdata_i(bus_wdata_i), .stat_o(kstat), .data_o(kdata)
  );

  console_disp #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) i_disp (
    .clk_i, .rst_ni, .step_i,
    .wr_stat_i(bus_we_i && sel == SEL_DSTAT),
    .wr_data_i(bus_we_i && sel == SEL_DDATA),
    .wdata_i(bus_wdata_i), .stat_o(dstat), .data_o(ddata),
    .out_valid_o, .out_char_o
  );

  assign wr_mctl  = bus_we_i && sel == SEL_MCTL;
  assign mem_we_o = bus_we_i && !hit;
  assign run_o    = (mctl_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mctl_q <= DATA_W'(1);
    else if (wr_mctl) mctl_q <= bus_wdata_i;
  end

  // R4
  halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == MCTL_A && bus_wdata_i == '0) |=> !run_o);

  // R3
  reg_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == KDATA_A && !in_valid_i) |=> (kdata == $past(bus_wdata_i)));
endmodule

// File: tb/test_console_regs.sv
module test_console_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [15:0] addr = 16'h3000;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] mem_rdata = 16'hBEEF;
  logic        mem_we;
  logic        in_valid = 1'b0;
  logic [7:0]  in_char = '0;
  logic        out_valid;
  logic [7:0]  out_char;
  logic        run;

  int total = 0;
  int bad = 0;

  localparam logic [15:0] KS = 16'hFE00, KD = 16'hFE02, DS = 16'hFE04, DD = 16'hFE06, MC = 16'hFFFE;

  always #10 clk = ~clk;

  console_regs i_console_regs (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .mem_rdata_i(mem_rdata), .mem_we_o(mem_we),
    .in_valid_i(in_valid), .in_char_i(in_char), .out_valid_o(out_valid),
    .out_char_o(out_char), .run_o(run)
  );

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rd(logic [15:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  // one step strobe; returns output seen in the cycle after the edge
  task automatic do_step(output logic v, output logic [7:0] c);
    @(negedge clk);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    v = out_valid; c = out_char;
  endtask

  task automatic arrive(logic [7:0] ch);
    @(negedge clk);
    in_valid = 1'b1; in_char = ch;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(KS, v); chk("R1", "kbd status", v, 16'h0000);
    rd(KD, v); chk("R1", "kbd data", v, 16'h0000);
    rd(DS, v); chk("R1", "disp status", v, 16'hFFFF);
    rd(DD, v); chk("R1", "disp data", v, 16'h0000);
    rd(MC, v); chk("R1", "mctl", v, 16'h0001);
    chk("R1", "run", {15'b0, run}, 16'h1);
    chk("R1", "out_valid", {15'b0, out_valid}, 16'h0);
  endtask

  task automatic t_pass;
    logic [15:0] v;
    rd(16'h3000, v); chk("R2", "mem read", v, 16'hBEEF);
    rd(16'hFE01, v); chk("R2", "neighbour read", v, 16'hBEEF);
    rd(16'hFFFF, v); chk("R2", "above mctl read", v, 16'hBEEF);
    @(negedge clk);
    addr = 16'h3000; we = 1'b1; wdata = 16'h1234;
    #1 chk("R3", "mem_we on memory addr", {15'b0, mem_we}, 16'h1);
    addr = 16'hFE01;
    #1 chk("R3", "mem_we on neighbour", {15'b0, mem_we}, 16'h1);
    addr = DD;
    #1 chk("R3", "mem_we on reg addr", {15'b0, mem_we}, 16'h0);
    addr = 16'hFE01;
    @(negedge clk);
    we = 1'b0;
    rd(DD, v); chk("R3", "neighbour write leaves regs", v, 16'h0000);
    rd(KS, v); chk("R3", "neighbour write leaves kbd", v, 16'h0000);
  endtask

  task automatic t_regrw;
    logic [15:0] v;
    wr(KD, 16'hA5C3); rd(KD, v); chk("R3", "kbd data write", v, 16'hA5C3);
    wr(KD, 16'h0000);
    wr(DS, 16'h0003); rd(DS, v); chk("R3", "disp status write", v, 16'h0003);
    wr(DS, 16'hFFFF);
  endtask

  task automatic t_halt;
    logic [15:0] v;
    wr(MC, 16'h0000);
    chk("R4", "run after zero", {15'b0, run}, 16'h0);
    rd(MC, v); chk("R4", "mctl zero", v, 16'h0000);
    wr(MC, 16'h8000);
    chk("R4", "run after nonzero", {15'b0, run}, 16'h1);
  endtask

  task automatic t_kbd;
    logic [15:0] v; logic ov; logic [7:0] oc;
    wr(KS, 16'h0003);
    arrive(8'h61);
    rd(KS, v); chk("R5", "ready set, low bits kept", v, 16'h8003);
    rd(KD, v); chk("R5", "kbd data", v, 16'h0061);
    do_step(ov, oc); do_step(ov, oc);
    rd(KS, v); chk("R6", "ready after 2 steps", v, 16'h8003);
    do_step(ov, oc);
    rd(KS, v); chk("R6", "ready cleared on 3rd step", v, 16'h0003);
    rd(KD, v); chk("R6", "data kept after timeout", v, 16'h0061);
    // restart of counter by a second arrival
    arrive(8'h62);
    do_step(ov, oc); do_step(ov, oc);
    arrive(8'h63);
    do_step(ov, oc); do_step(ov, oc);
    rd(KS, v); chk("R5", "counter restarted", v, 16'h8003);
    rd(KD, v); chk("R5", "latest char", v, 16'h0063);
    do_step(ov, oc);
    rd(KS, v); chk("R6", "cleared after restart", v, 16'h0003);
    // arrival together with a step
    do_step(ov, oc);
    @(negedge clk);
    in_valid = 1'b1; in_char = 8'h7A; step = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; step = 1'b0;
    do_step(ov, oc); do_step(ov, oc);
    rd(KS, v); chk("R9", "arrival wins over step", v, 16'h8003);
    do_step(ov, oc);
    rd(KS, v); chk("R9", "count restarted at same-cycle arrival", v, 16'h0003);
    wr(KS, 16'h0000);
  endtask

  task automatic t_disp;
    logic [15:0] v; logic ov; logic [7:0] oc;
    do_step(ov, oc);
    chk("R8", "no emit with zero data", {15'b0, ov}, 16'h0);
    rd(DS, v); chk("R8", "status ready", v, 16'hFFFF);
    wr(DD, 16'h0141);
    repeat (3) @(negedge clk);
    rd(DD, v); chk("R10", "data held between steps", v, 16'h0141);
    chk("R10", "no emit without step", {15'b0, out_valid}, 16'h0);
    do_step(ov, oc);
    chk("R7", "emit valid", {15'b0, ov}, 16'h1);
    chk("R7", "emit char", {8'h0, oc}, 16'h0041);
    @(negedge clk);
    chk("R7", "valid one cycle", {15'b0, out_valid}, 16'h0);
    rd(DS, v); chk("R7", "status busy", v, 16'h0001);
    rd(DD, v); chk("R7", "data cleared", v, 16'h0000);
    wr(DD, 16'h0042);
    do_step(ov, oc);
    chk("R8", "no emit while busy", {15'b0, ov}, 16'h0);
    rd(DS, v); chk("R8", "ready after busy step", v, 16'hFFFF);
    rd(DD, v); chk("R8", "data kept while busy", v, 16'h0042);
    do_step(ov, oc);
    chk("R8", "delayed emit valid", {15'b0, ov}, 16'h1);
    chk("R8", "delayed emit char", {8'h0, oc}, 16'h0042);
    // write priority on emitting step
    wr(DD, 16'h0043);
    do_step(ov, oc);
    chk("R8", "busy step", {15'b0, ov}, 16'h0);
    @(negedge clk);
    addr = DD; wdata = 16'h0044; we = 1'b1; step = 1'b1;
    @(negedge clk);
    we = 1'b0; step = 1'b0;
    chk("R9", "emit uses pre-edge data", {8'h0, out_char}, 16'h0043);
    chk("R9", "emit valid on write step", {15'b0, out_valid}, 16'h1);
    rd(DD, v); chk("R9", "write wins over clear", v, 16'h0044);
    rd(DS, v); chk("R9", "status busy", v, 16'h0001);
    do_step(ov, oc); do_step(ov, oc);
    chk("R9", "written char emitted later", {8'h0, oc}, 16'h0044);
  endtask

  initial begin
    #55 rst_n = 1'b1;
    t_reset();
    t_pass();
    t_regrw();
    t_halt();
    t_kbd();
    t_disp();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule